// File: doc/BRIEF.md
# Block Register Transfer Address Sequencer

This block runs the addressing for one load-multiple or store-multiple operation. A one-cycle start pulse presents a register-select mask, a base address, the index of the base register, a direction bit, a two-bit addressing type and a writeback request. The block latches these. It then issues one memory request for every selected register, each carrying a word address and the register index, over a valid/ready handshake.

The lowest-numbered register always lands at the lowest address, whichever of the four addressing types is chosen. After the last accepted request the block pulses done for one cycle. With that pulse it presents the updated base value and a flag saying whether the base register should take it.

On stores, a per-request flag marks the request whose data must be the updated base rather than the original one. Moving data, status-register handling and abort recovery are left to the surrounding pipeline.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset, `req_valid_o`, `done_o` and `wb_en_o` are all low.
- R2: For a non-empty mask, exactly one request is issued per set bit, in rising register-index order, and `req_write_o` is the inverse of the latched `load_i`.
- R3: With n set bits, the addressing type `mode_i` selects the first address: 2'b10 gives base, 2'b11 gives base+4, 2'b00 gives base-4n+4, and 2'b01 gives base-4n. Each later request is 4 above the one before it.
- R4: While `req_valid_o` is high and `req_ready_i` is low, the request and its address and index stay unchanged in the next cycle.
- R5: `done_o` is high for exactly one cycle, the cycle after the last accepted request. `wb_val_o` is then base+4n for types 2'b10 and 2'b11 and base-4n for types 2'b00 and 2'b01. `wb_en_o` is only ever high together with `done_o`.
- R6: A load whose mask includes the base register leaves `wb_en_o` low at done.
- R7: When the base index is the highest register (NREGS-1), `wb_en_o` stays low at done.
- R8: On a store with effective writeback, `req_new_base_o` is high on the request for the base register exactly when the base is not the lowest selected register. It is low on all other requests.
- R9: An empty mask issues no request and raises `done_o` on the cycle after start. `wb_val_o` then equals the base.
- R10: A start pulse while a transfer is in progress is ignored and does not disturb the running sequence.
- R11: With writeback not requested, `wb_en_o` stays low at done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a transfer (sampled when idle) |
| list_i | input | NREGS | Register-select mask, bit i selects register i |
| base_i | input | AW | Base address |
| base_idx_i | input | $clog2(NREGS) | Index of the base register |
| load_i | input | 1 | 1 = load, 0 = store |
| mode_i | input | 2 | Addressing type: bit 1 = upward, bit 0 = adjust before access |
| wb_i | input | 1 | Writeback requested |
| req_valid_o | output | 1 | Request valid |
| req_ready_i | input | 1 | Memory side accepts request |
| req_addr_o | output | AW | Word address of request |
| req_idx_o | output | $clog2(NREGS) | Register index of request |
| req_write_o | output | 1 | Request is a store |
| req_new_base_o | output | 1 | Store the updated base for this request |
| done_o | output | 1 | One-cycle completion pulse |
| wb_en_o | output | 1 | Base register takes `wb_val_o` |
| wb_val_o | output | AW | Final base value |

## Verification
The bench builds the block with its default 16 registers and 32-bit addresses. This makes register 15 a reachable base index for the writeback-suppression case, and a full 16-bit mask exercises the longest run in a decrementing type. The defaults also let the wrap-free address arithmetic be predicted in the bench with plain 32-bit sums. Stalled handshakes and a start pulse during a run are mixed into the directed scenarios.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;
  // bit 1: upward, bit 0: adjust before access
  typedef enum logic [1:0] {
    DN_AFTER  = 2'b00,
    DN_BEFORE = 2'b01,
    UP_AFTER  = 2'b10,
    UP_BEFORE = 2'b11
  } xfer_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_XFER = 1'b1
  } seq_state_e;
endpackage

// File: rtl/blk_popcnt.sv
module blk_popcnt #(
  parameter int W  = 16,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) begin
      cnt_o = cnt_o + CW'(vec_i[i]);
    end
  end
endmodule

// File: rtl/blk_lowbit.sv
module blk_lowbit #(
  parameter int W  = 16,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o
);
  // scan downward so the lowest set bit wins
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/blk_addr_gen.sv
module blk_addr_gen
  import blk_xfer_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 5
) (
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [1:0]    mode_i,
  output logic [AW-1:0] first_o,
  output logic [AW-1:0] final_o
);
  logic [AW-1:0] span;
  xfer_mode_e    md;

  assign span = AW'(cnt_i) << 2;
  assign md   = xfer_mode_e'(mode_i);

  always_comb begin
    unique case (md)
      UP_AFTER:  first_o = base_i;
      UP_BEFORE: first_o = base_i + AW'(4);
      DN_AFTER:  first_o = base_i - span + AW'(4);
      default:   first_o = base_i - span;
    endcase
    final_o = md[1] ? (base_i + span) : (base_i - span);
  end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import blk_xfer_pkg::*;
#(
  parameter int NREGS = 16,
  parameter int AW    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [NREGS-1:0]         list_i,
  input  logic [AW-1:0]            base_i,
  input  logic [$clog2(NREGS)-1:0] base_idx_i,
  input  logic                     load_i,
  input  logic [1:0]               mode_i,
  input  logic                     wb_i,
  output logic                     req_valid_o,
  input  logic                     req_ready_i,
  output logic [AW-1:0]            req_addr_o,
  output logic [$clog2(NREGS)-1:0] req_idx_o,
  output logic                     req_write_o,
  output logic                     req_new_base_o,
  output logic                     done_o,
  output logic                     wb_en_o,
  output logic [AW-1:0]            wb_val_o
);
  localparam int IW = $clog2(NREGS);
  localparam int CW = $clog2(NREGS + 1);
  localparam logic [IW-1:0] TOP_IDX = IW'(NREGS - 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  seq_state_e       state_q, state_d;
  logic             done_q, done_d;
  logic [NREGS-1:0] rem_q, rem_clr;
  logic [AW-1:0]    addr_q, wbval_q;
  logic             load_q, wbe_q, blow_q;
  logic [IW-1:0]    bidx_q;
  logic             cap_en, step_en;

  logic [CW-1:0]    cnt;
  logic [AW-1:0]    first_addr, final_addr;
  logic [IW-1:0]    list_low, cur_idx;
  logic             base_low, wb_eff;

  blk_popcnt #(.W(NREGS), .CW(CW)) u_cnt (.vec_i(list_i), .cnt_o(cnt));

  blk_addr_gen #(.AW(AW), .CW(CW)) u_addr (
    .base_i(base_i), .cnt_i(cnt), .mode_i(mode_i),
    .first_o(first_addr), .final_o(final_addr)
  );

  blk_lowbit #(.W(NREGS), .IW(IW)) u_low_list (.vec_i(list_i), .idx_o(list_low));
  blk_lowbit #(.W(NREGS), .IW(IW)) u_low_rem  (.vec_i(rem_q),  .idx_o(cur_idx));

  assign base_low = list_i[base_idx_i] && (list_low == base_idx_i);
  assign wb_eff   = wb_i && (base_idx_i != TOP_IDX) && !(load_i && list_i[base_idx_i]);
  assign rem_clr  = rem_q & (rem_q - NREGS'(1));

  // next-state
  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    cap_en  = 1'b0;
    step_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          cap_en = 1'b1;
          if (list_i == '0) done_d  = 1'b1;
          else              state_d = ST_XFER;
        end
      end
      default: begin
        if (req_ready_i) begin
          step_en = 1'b1;
          if (rem_clr == '0) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end
      end
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  // datapath registers with explicit enables
  always_ff @(posedge clk) begin
    if (cap_en) begin
      rem_q   <= list_i;
      addr_q  <= first_addr;
      wbval_q <= final_addr;
      load_q  <= load_i;
      wbe_q   <= wb_eff;
      bidx_q  <= base_idx_i;
      blow_q  <= base_low;
    end else if (step_en) begin
      rem_q   <= rem_clr;
      addr_q  <= addr_q + AW'(4);
    end
  end

  assign req_valid_o    = (state_q == ST_XFER);
  assign req_addr_o     = addr_q;
  assign req_idx_o      = cur_idx;
  assign req_write_o    = !load_q;
  assign req_new_base_o = req_valid_o && !load_q && wbe_q && !blow_q && (cur_idx == bidx_q);
  assign done_o         = done_q;
  assign wb_en_o        = done_q && wbe_q;
  assign wb_val_o       = wbval_q;
endmodule

// File: rtl/blk_xfer_seq_chk.sv
module blk_xfer_seq_chk #(
  parameter int NREGS = 16,
  parameter int AW    = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid_o,
  input logic                     req_ready_i,
  input logic [AW-1:0]            req_addr_o,
  input logic [$clog2(NREGS)-1:0] req_idx_o,
  input logic                     req_write_o,
  input logic                     req_new_base_o,
  input logic                     done_o,
  input logic                     wb_en_o
);
  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o) && $stable(req_idx_o)));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && req_ready_i) |=> (!req_valid_o || req_addr_o == $past(req_addr_o) + AW'(4)));

  // R2
  idx_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && req_ready_i) |=> (!req_valid_o || req_idx_o > $past(req_idx_o)));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R5
  wb_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en_o |-> done_o);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !req_valid_o);

  // R8
  new_base_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_new_base_o |-> (req_valid_o && req_write_o));
endmodule

bind blk_xfer_seq blk_xfer_seq_chk #(.NREGS(NREGS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
  .req_addr_o(req_addr_o), .req_idx_o(req_idx_o), .req_write_o(req_write_o),
  .req_new_base_o(req_new_base_o), .done_o(done_o), .wb_en_o(wb_en_o)
);

// File: tb/blk_xfer_seq_bench.sv
module blk_xfer_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [15:0] list_i;
  logic [31:0] base_i;
  logic [3:0]  base_idx_i;
  logic        load_i;
  logic [1:0]  mode_i;
  logic        wb_i;
  logic        req_valid_o;
  logic        req_ready_i;
  logic [31:0] req_addr_o;
  logic [3:0]  req_idx_o;
  logic        req_write_o;
  logic        req_new_base_o;
  logic        done_o;
  logic        wb_en_o;
  logic [31:0] wb_val_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  blk_xfer_seq u_blk_xfer_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .list_i(list_i), .base_i(base_i),
    .base_idx_i(base_idx_i), .load_i(load_i), .mode_i(mode_i), .wb_i(wb_i),
    .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_addr_o(req_addr_o),
    .req_idx_o(req_idx_o), .req_write_o(req_write_o), .req_new_base_o(req_new_base_o),
    .done_o(done_o), .wb_en_o(wb_en_o), .wb_val_o(wb_val_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // R1: quiet outputs after reset
  task automatic t_reset();
    @(negedge clk);
    chk({req_valid_o, done_o, wb_en_o} == 3'b000, "R1", "reset outputs",
        64'({req_valid_o, done_o, wb_en_o}), 64'd0);
  endtask

  // Runs one transfer and checks every request and the completion (R2..R11)
  task automatic run_xfer(input string tag, input logic [15:0] lst, input logic [31:0] base,
                          input logic [3:0] bidx, input logic ld, input logic [1:0] md,
                          input logic wbf, input bit stall, input bit poke);
    int n = 0;
    int k = 0;
    int cyc = 0;
    int lowest = -1;
    int order[16];
    logic [31:0] first, fin, span;
    logic wbeff, expnb;
    logic [39:0] act, exp;
    for (int i = 0; i < 16; i++) begin
      if (lst[i]) begin
        order[n] = i;
        if (lowest < 0) lowest = i;
        n++;
      end
    end
    span = 32'(4 * n);
    case (md)
      2'b10:   first = base;
      2'b11:   first = base + 32'd4;
      2'b00:   first = base - span + 32'd4;
      default: first = base - span;
    endcase
    fin   = md[1] ? base + span : base - span;
    wbeff = wbf && (bidx != 4'd15) && !(ld && lst[bidx]);

    @(negedge clk);
    start_i = 1'b1; list_i = lst; base_i = base; base_idx_i = bidx;
    load_i = ld; mode_i = md; wb_i = wbf; req_ready_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    while (k < n && cyc < 200) begin
      expnb = !ld && wbeff && (order[k] == int'(bidx)) && (lowest != int'(bidx));
      act = {req_valid_o, req_write_o, req_new_base_o, 1'b0, req_idx_o, req_addr_o};
      exp = {1'b1, !ld, expnb, 1'b0, 4'(order[k]), first + 32'(4 * k)};
      chk(act == exp, tag, "request {valid,write,newbase,idx,addr}", 64'(act), 64'(exp));
      if (poke && cyc == 0) begin
        start_i = 1'b1; list_i = 16'hFFFF; base_i = 32'h0; load_i = !ld;
      end
      req_ready_i = stall ? cyc[0] : 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      if (req_ready_i) k++;
      cyc++;
    end
    req_ready_i = 1'b0;
    chk(done_o && !req_valid_o, tag, "done after last request",
        64'({done_o, req_valid_o}), 64'b10);
    chk(wb_en_o == wbeff, tag, "writeback enable", 64'(wb_en_o), 64'(wbeff));
    chk(wb_val_o == fin, tag, "writeback value", 64'(wb_val_o), 64'(fin));
    @(negedge clk);
    chk(!done_o && !req_valid_o, tag, "done is one pulse",
        64'({done_o, req_valid_o}), 64'b00);
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; list_i = '0; base_i = '0; base_idx_i = '0;
    load_i = 1'b0; mode_i = 2'b00; wb_i = 1'b0; req_ready_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    // R2 R3 R5: store, upward after, base outside mask
    run_xfer("R3_up_after", 16'h00F0, 32'h1000, 4'd13, 1'b0, 2'b10, 1'b1, 1'b0, 1'b0);
    // R4: load, upward before, stalled handshakes
    run_xfer("R4_stall", 16'h8005, 32'h2000, 4'd1, 1'b1, 2'b11, 1'b1, 1'b1, 1'b0);
    // R8: base is lowest register, original value stored
    run_xfer("R8_base_lowest", 16'h0032, 32'h3000, 4'd1, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0);
    // R8: base not lowest, updated value flagged
    run_xfer("R8_base_upper", 16'h0036, 32'h4000, 4'd4, 1'b0, 2'b01, 1'b1, 1'b0, 1'b0);
    // R6: load containing base keeps loaded value
    run_xfer("R6_load_base", 16'h0110, 32'h5000, 4'd4, 1'b1, 2'b01, 1'b1, 1'b0, 1'b0);
    // R7: highest register as base
    run_xfer("R7_top_base", 16'h0003, 32'h6000, 4'd15, 1'b0, 2'b10, 1'b1, 1'b0, 1'b0);
    // R9: empty mask
    run_xfer("R9_empty", 16'h0000, 32'h7000, 4'd2, 1'b0, 2'b10, 1'b1, 1'b0, 1'b0);
    // R10: start while busy, full mask downward before with stalls
    run_xfer("R10_busy_start", 16'hFFFF, 32'h8000, 4'd13, 1'b0, 2'b01, 1'b1, 1'b1, 1'b1);
    // R11: no writeback requested
    run_xfer("R11_no_wb", 16'h0C00, 32'h9000, 4'd10, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule